// File: doc/BRIEF.md
# Firmware Hub Command Interpreter

This block models the command front end of a firmware flash device attached to a byte-wide bus. A bus master issues single-cycle read and write strobes with an address and a data byte. Every write is taken as a command byte, and the address that comes with it plays no part in decoding. The interpreter has two modes. In array mode, reads return bytes from a small internal ROM. In identification mode, the two lowest addresses return the manufacturer code and the device code, and the array stays hidden until the master writes the read-array command.

Command writes are accepted only while the host bridge's firmware write-enable bit is set. The input carrying that bit is `bios_we_i`. A bridge that has locked the firmware space read-only leaves write-enable clear, so command writes are ignored in that state too. Reads return their data one cycle after the strobe, and `rvalid_o` marks that cycle. The current mode is brought out on `id_mode_o`.

Top module: `fwh_cmd_core`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the interpreter is in array mode: `id_mode_o`=0, `rvalid_o`=0 and `rdata_o`=0x00. Asserting reset while in identification mode also returns it to array mode.
- R2: In array mode, a read at address A gives `rdata_o` = (A*ROM_MUL + ROM_SEED) mod 256 in the cycle after the read strobe. The defaults are ROM_MUL=37 and ROM_SEED=0x5A.
- R3: A write of 0x90 with `bios_we_i`=1 enters identification mode (`id_mode_o`=1) from the next cycle on, at any address.
- R4: In identification mode, a read at address 0 returns the manufacturer code 0x89.
- R5: In identification mode, a read at address 1 returns the device code. It is 0xAC when DEV_8M=1 (the default) and 0xAD when DEV_8M=0.
- R6: In identification mode, a read at any address other than 0 and 1 returns 0x00.
- R7: A write of 0xFF with `bios_we_i`=1 returns the interpreter to array mode at any address. Array data becomes readable again from that point on.
- R8: A write of any byte other than 0x90 and 0xFF leaves the mode unchanged.
- R9: A write with `bios_we_i`=0 has no effect on the mode, whatever the byte.
- R10: `rvalid_o` is high exactly in the cycle after each read strobe. `rdata_o` holds its value when no read is issued.
- R11: A read issued in the same cycle as a command write is served in the mode in effect before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| wr_en_i | input | 1 | Write strobe; the write data is a command byte |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Command byte |
| bios_we_i | input | 1 | Bridge firmware write-enable bit |
| rdata_o | output | 8 | Read data, valid one cycle after the strobe |
| rvalid_o | output | 1 | Read data valid |
| id_mode_o | output | 1 | High while identification mode is active |

## Verification
Reads are tried at address 0, at address 1 and at further addresses in both modes. This separates the array contents from the identification codes and from the zero fill. Commands are written at addresses other than zero, which shows that the address is ignored. Unrelated bytes and writes with write-enable clear are each followed by a read or a mode check, which tells an ignored write apart from a mode change. A read issued in the same cycle as a mode switch shows whether it is served in the old mode or the new one. A second instance built for the 4-Mbit variant checks the alternate device code.

// File: rtl/fwh_pkg.sv
package fwh_pkg;
  typedef enum logic {
    MODE_ARRAY = 1'b0,
    MODE_ID    = 1'b1
  } fwh_mode_e;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_READ_ID    = 8'h90;
  localparam logic [7:0] CODE_MFR       = 8'h89;
  localparam logic [7:0] CODE_DEV_8M    = 8'hAC;
  localparam logic [7:0] CODE_DEV_4M    = 8'hAD;
  localparam int unsigned ID_ADDR_MFR   = 0;
  localparam int unsigned ID_ADDR_DEV   = 1;
endpackage

// File: rtl/fwh_cmd_decode.sv
module fwh_cmd_decode
  import fwh_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wdata_i,
  input  logic       bios_we_i,
  output fwh_mode_e  mode_o
);
  fwh_mode_e mode_q, mode_d;
  logic      cmd_ok;

  // address is not an input: command decode is address-blind
  assign cmd_ok = wr_en_i & bios_we_i;

  always_comb begin
    mode_d = mode_q;
    if (cmd_ok) begin
      unique case (wdata_i)
        CMD_READ_ID:    mode_d = MODE_ID;
        CMD_READ_ARRAY: mode_d = MODE_ARRAY;
        default:        mode_d = mode_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_ARRAY;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/fwh_array_rom.sv
module fwh_array_rom #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned ROM_MUL  = 37,
  parameter logic [7:0]  ROM_SEED = 8'h5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  function automatic logic [7:0] cell_val(input int unsigned idx);
    int unsigned v;
    v = idx * ROM_MUL + int'(ROM_SEED);
    return v[7:0];
  endfunction

  logic [7:0] rom_tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    assign rom_tbl[g] = cell_val(g);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (rd_en_i) data_o <= rom_tbl[addr_i];
  end
endmodule

// File: rtl/fwh_id_space.sv
module fwh_id_space
  import fwh_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter bit          DEV_8M = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        data_o
);
  logic [7:0] dev_code;
  logic [7:0] id_d;

  if (DEV_8M) begin : g_dev_8m
    assign dev_code = CODE_DEV_8M;
  end else begin : g_dev_4m
    assign dev_code = CODE_DEV_4M;
  end

  always_comb begin
    if (addr_i == ADDR_W'(ID_ADDR_MFR))      id_d = CODE_MFR;
    else if (addr_i == ADDR_W'(ID_ADDR_DEV)) id_d = dev_code;
    else                                     id_d = 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (rd_en_i) data_o <= id_d;
  end
endmodule

// File: rtl/fwh_rd_mux.sv
module fwh_rd_mux
  import fwh_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_en_i,
  input  fwh_mode_e  mode_i,
  input  logic [7:0] arr_data_i,
  input  logic [7:0] id_data_i,
  output logic [7:0] rdata_o,
  output logic       rvalid_o
);
  fwh_mode_e sel_q;

  // mode latched with the read so a same-cycle command cannot redirect it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= MODE_ARRAY;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) sel_q <= mode_i;
    end
  end

  assign rdata_o = (sel_q == MODE_ID) ? id_data_i : arr_data_i;
endmodule

// File: rtl/fwh_cmd_core.sv
module fwh_cmd_core
  import fwh_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned ROM_MUL  = 37,
  parameter logic [7:0]  ROM_SEED = 8'h5A,
  parameter bit          DEV_8M   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              bios_we_i,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o,
  output logic              id_mode_o
);
  fwh_mode_e  mode;
  logic [7:0] arr_data;
  logic [7:0] id_data;

  fwh_cmd_decode i_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wdata_i   (wdata_i),
    .bios_we_i (bios_we_i),
    .mode_o    (mode)
  );

  fwh_array_rom #(
    .ADDR_W   (ADDR_W),
    .ROM_MUL  (ROM_MUL),
    .ROM_SEED (ROM_SEED)
  ) i_rom (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .data_o  (arr_data)
  );

  fwh_id_space #(
    .ADDR_W (ADDR_W),
    .DEV_8M (DEV_8M)
  ) i_id (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .data_o  (id_data)
  );

  fwh_rd_mux i_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .mode_i     (mode),
    .arr_data_i (arr_data),
    .id_data_i  (id_data),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

  assign id_mode_o = (mode == MODE_ID);
endmodule

// File: rtl/fwh_cmd_core_chk.sv
module fwh_cmd_core_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter bit          DEV_8M = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              bios_we_i,
  input logic [7:0]        rdata_o,
  input logic              rvalid_o,
  input logic              id_mode_o
);
  localparam logic [7:0] EXP_DEV = DEV_8M ? 8'hAC : 8'hAD;

  AST_ENTER_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && bios_we_i && wdata_i == 8'h90) |=> id_mode_o); // R3
  AST_EXIT_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && bios_we_i && wdata_i == 8'hFF) |=> !id_mode_o); // R7
  AST_OTHER_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && bios_we_i && wdata_i != 8'h90 && wdata_i != 8'hFF) |=> $stable(id_mode_o)); // R8
  AST_NO_WE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !bios_we_i) |=> $stable(id_mode_o)); // R9
  AST_ID_MFR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && id_mode_o && addr_i == '0) |=> rdata_o == 8'h89); // R4
  AST_ID_DEV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && id_mode_o && addr_i == ADDR_W'(1)) |=> rdata_o == EXP_DEV); // R5
  AST_ID_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && id_mode_o && addr_i > ADDR_W'(1)) |=> rdata_o == 8'h00); // R6
  AST_RVALID_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o); // R10
  AST_RVALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R10
endmodule

bind fwh_cmd_core fwh_cmd_core_chk #(
  .ADDR_W (ADDR_W),
  .DEV_8M (DEV_8M)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_en_i   (rd_en_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .bios_we_i (bios_we_i),
  .rdata_o   (rdata_o),
  .rvalid_o  (rvalid_o),
  .id_mode_o (id_mode_o)
);

// File: tb/test_fwh_cmd_core.sv
module test_fwh_cmd_core;
  localparam int CLK_PERIOD = 10;

  typedef enum logic [1:0] {K_RD_LIT = 2'd0, K_RD_ROM = 2'd1, K_WR = 2'd2} kind_e;
  typedef struct packed {
    kind_e      kind;
    logic [7:0] addr;
    logic [7:0] data;   // write byte, or expected literal read data
    logic       we;
    logic       exp_id;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VECS [NVEC] = '{
    '{K_RD_ROM, 8'h00, 8'h00, 1'b0, 1'b0},  // R2
    '{K_RD_ROM, 8'h13, 8'h00, 1'b0, 1'b0},  // R2
    '{K_WR,     8'h77, 8'h90, 1'b1, 1'b1},  // R3 non-zero address
    '{K_RD_LIT, 8'h00, 8'h89, 1'b0, 1'b1},  // R4
    '{K_RD_LIT, 8'h01, 8'hAC, 1'b0, 1'b1},  // R5
    '{K_RD_LIT, 8'h02, 8'h00, 1'b0, 1'b1},  // R6
    '{K_RD_LIT, 8'hFF, 8'h00, 1'b0, 1'b1},  // R6
    '{K_WR,     8'h00, 8'h12, 1'b1, 1'b1},  // R8
    '{K_WR,     8'h00, 8'hFF, 1'b0, 1'b1},  // R9
    '{K_RD_LIT, 8'h00, 8'h89, 1'b0, 1'b1},  // R9 still ID
    '{K_WR,     8'h40, 8'hFF, 1'b1, 1'b0},  // R7 non-zero address
    '{K_RD_ROM, 8'h00, 8'h00, 1'b0, 1'b0},  // R7
    '{K_RD_ROM, 8'h01, 8'h00, 1'b0, 1'b0},  // R7
    '{K_WR,     8'h00, 8'h90, 1'b0, 1'b0},  // R9
    '{K_RD_ROM, 8'h01, 8'h00, 1'b0, 1'b0},  // R9 array visible
    '{K_WR,     8'h05, 8'h00, 1'b1, 1'b0},  // R8
    '{K_WR,     8'h00, 8'h90, 1'b1, 1'b1},  // R3
    '{K_WR,     8'h01, 8'h90, 1'b1, 1'b1},  // R3 repeated
    '{K_WR,     8'hC3, 8'hFF, 1'b1, 1'b0}   // R7
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       bios_we = 1'b0;
  logic [7:0] rdata, rdata_4m;
  logic       rvalid, rvalid_4m;
  logic       id_mode, id_mode_4m;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fwh_cmd_core i_fwh_cmd_core (
    .clk_i (clk), .rst_ni (rst_n), .rd_en_i (rd_en), .wr_en_i (wr_en),
    .addr_i (addr), .wdata_i (wdata), .bios_we_i (bios_we),
    .rdata_o (rdata), .rvalid_o (rvalid), .id_mode_o (id_mode)
  );

  fwh_cmd_core #(.DEV_8M(1'b0)) i_fwh_cmd_core_4m (
    .clk_i (clk), .rst_ni (rst_n), .rd_en_i (rd_en), .wr_en_i (wr_en),
    .addr_i (addr), .wdata_i (wdata), .bios_we_i (bios_we),
    .rdata_o (rdata_4m), .rvalid_o (rvalid_4m), .id_mode_o (id_mode_4m)
  );

  function automatic logic [7:0] rom_exp(input logic [7:0] a);
    int unsigned v;
    v = int'(a) * 37 + 32'h5A;
    return v[7:0];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic op(input logic rd, input logic wr, input logic [7:0] a,
                    input logic [7:0] d, input logic we);
    rd_en = rd; wr_en = wr; addr = a; wdata = d; bios_we = we;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mode in reset", {7'd0, id_mode}, 8'h00);
    chk("R1 rvalid in reset", {7'd0, rvalid}, 8'h00);
    chk("R1 rdata in reset", rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode after reset", {7'd0, id_mode}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VECS[i];
      if (v.kind == K_WR) begin
        op(1'b0, 1'b1, v.addr, v.data, v.we);
        chk("R3/R7/R8/R9 mode after write", {7'd0, id_mode}, {7'd0, v.exp_id});
      end else begin
        op(1'b1, 1'b0, v.addr, 8'h00, 1'b0);
        chk("R10 rvalid after read", {7'd0, rvalid}, 8'h01);
        chk("R2/R4/R5/R6 read data", rdata,
            (v.kind == K_RD_ROM) ? rom_exp(v.addr) : v.data);
        chk("R3/R7/R8/R9 mode held by read", {7'd0, id_mode}, {7'd0, v.exp_id});
      end
    end

    // R10: idle cycle after a read
    op(1'b1, 1'b0, 8'h05, 8'h00, 1'b0);
    chk("R2 array read addr 5", rdata, rom_exp(8'h05));
    @(negedge clk);
    chk("R10 rvalid drops", {7'd0, rvalid}, 8'h00);
    chk("R10 rdata held", rdata, rom_exp(8'h05));

    // R11: read and ID command in the same cycle
    rd_en = 1'b1; wr_en = 1'b1; addr = 8'h00; wdata = 8'h90; bios_we = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk("R11 read served in old array mode", rdata, rom_exp(8'h00));
    chk("R11 mode switched", {7'd0, id_mode}, 8'h01);
    op(1'b1, 1'b0, 8'h00, 8'h00, 1'b0);
    chk("R11 next read in ID mode", rdata, 8'h89);

    // R5: 4-Mbit variant
    op(1'b1, 1'b0, 8'h01, 8'h00, 1'b0);
    chk("R5 device code 8M", rdata, 8'hAC);
    chk("R5 device code 4M", rdata_4m, 8'hAD);

    // R11: read and exit command in the same cycle
    rd_en = 1'b1; wr_en = 1'b1; addr = 8'h00; wdata = 8'hFF; bios_we = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk("R11 read served in old ID mode", rdata, 8'h89);
    chk("R7 mode back to array", {7'd0, id_mode}, 8'h00);

    // R1: reset while in ID mode
    op(1'b0, 1'b1, 8'h00, 8'h90, 1'b1);
    chk("R3 enter ID before reset", {7'd0, id_mode}, 8'h01);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset leaves ID mode", {7'd0, id_mode}, 8'h00);
    op(1'b1, 1'b0, 8'h01, 8'h00, 1'b0);
    chk("R1 array visible after reset", rdata, rom_exp(8'h01));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule